// File: doc/BRIEF.md
# Receive Byte Buffer with Watermark Flow Control

This block sits between a serial receiver and a host-side reader. Each byte the receiver strobes in is stored in a first-in first-out buffer of 480 entries. The reader sees the oldest stored byte at all times, together with an empty flag and the current fill count. It consumes that byte with a read strobe. A flush command discards everything held, and the host issues it whenever the port is opened.

The control logic also drives two pins. The first is an active-low ready-to-send line. It asks the remote sender to pause once the buffer holds 450 bytes, which leaves 30 entries of slack for bytes already in flight. It releases the pause as soon as a read brings the count below that mark; there is no hysteresis. The second is a receive-activity LED line. It rests high while no reception is in progress and toggles on every pulse of an external slow tick (nominally 10 Hz) while a reception is running.

A byte that arrives while all 480 entries are occupied is discarded, and a sticky overrun flag records the loss until the next flush or reset.

Top module: `rxbuf_flow`

## Requirements
- R1: While reset is asserted (synchronous, active low), the block clears itself. After the clock edge that samples reset low: `level` is 0, `empty` is 1, `overrun` is 0, `rts_n` is 0 and `rx_led` is 1.
- R2: Bytes are returned in arrival order. Whenever `empty` is 0, `rd_data` shows the oldest stored byte, and a read advances to the next one.
- R3: An accepted write raises `level` by one, and a read of a non-empty buffer lowers it by one. A write and a read in the same cycle leave it unchanged. Each change is visible after the clock edge that samples the strobes.
- R4: The capacity is 480 bytes. A write strobed while `level` is 480 is dropped, even if a read happens in the same cycle. In that case `level` stays at 480 and `overrun` goes to 1 and stays 1 until a flush or reset.
- R5: `rts_n` is 0 while `level` is below 450 and 1 while `level` is 450 or more. It changes on the same clock edge as `level`.
- R6: With no hysteresis, `rts_n` returns to 0 on the edge where a read takes `level` from 450 to 449.
- R7: A read strobe while the buffer is empty has no effect. `level` stays 0 and, if a write is strobed in the same cycle, that byte is stored and becomes `rd_data`.
- R8: A flush empties the buffer and clears `overrun` on the next edge. It takes priority over a write or read strobed in the same cycle, and the write is not stored.
- R9: When `rx_busy` is 0 at a clock edge, `rx_led` is 1 after that edge, whatever `blink_tick` does.
- R10: When `rx_busy` is 1, `rx_led` inverts on each edge where `blink_tick` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | Write strobe for `rx_data` |
| rx_busy | input | 1 | High while a reception is in progress |
| rd_en | input | 1 | Host read strobe, consumes `rd_data` |
| flush | input | 1 | Discard all stored bytes and clear overrun |
| blink_tick | input | 1 | One-cycle pulse at the LED toggle rate |
| rd_data | output | 8 | Oldest stored byte |
| empty | output | 1 | High when no byte is stored |
| level | output | 9 | Number of stored bytes, 0 to 480 |
| overrun | output | 1 | Sticky flag for a byte dropped while full |
| rts_n | output | 1 | Ready to send, active low |
| rx_led | output | 1 | Receive activity indicator, high at idle |

## Verification
`level`, `empty`, `overrun`, `rts_n` and `rx_led` are all registered, so every one of them is due exactly one clock edge after the strobe that causes it. `rd_data` follows the read pointer combinationally and shows the new head byte after that same edge. The bench drives each stimulus 1 ns after a rising edge and samples the results 1 ns after the next rising edge, which is the single edge at which they are due. It reads `rd_data` just before issuing the read strobe that consumes it.

// File: rtl/rxbuf_pkg.sv
// Shared types for the receive buffer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rxbuf_pkg;

    // Combined buffer operation for one cycle: {push, pop}
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } buf_op_e;

endpackage

// File: rtl/rxbuf_ptr.sv
// Circular pointer over DEPTH slots.
// A power-of-two depth wraps by natural overflow; any other depth
// wraps with a compare against the last slot.
// Assumes clr and adv are never needed in the same cycle with adv winning.
module rxbuf_ptr #(
    parameter int DEPTH = 480,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam bit            POW2 = ((1 << AW) == DEPTH);

    logic [AW-1:0] ptr_inc;

    generate
        if (POW2) begin : g_pow2
            // Wrap by overflow
            always_comb ptr_inc = ptr + AW'(1);
        end else begin : g_cmp
            // Wrap at the last slot
            always_comb ptr_inc = (ptr == LAST) ? '0 : ptr + AW'(1);
        end
    endgenerate

    // Pointer register: clear beats advance
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ptr <= '0;
        else if (adv)      ptr <= ptr_inc;
    end

endmodule

// File: rtl/rxbuf_mem.sv
// Byte storage with one write port and an asynchronous read port.
// Assumes the caller never writes a slot that holds unread data.
module rxbuf_mem #(
    parameter int DEPTH = 480,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    // Write port, no reset on storage
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Show-ahead read of the head slot
    always_comb rdata = store[raddr];

endmodule

// File: rtl/rxbuf_ctrl.sv
// Occupancy control: decides push/pop, tracks the fill level,
// the sticky overrun flag, the empty flag and the ready-to-send pin.
// Assumes WMARK <= DEPTH.
module rxbuf_ctrl
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 480,
    parameter int WMARK = 450,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rd_en,
    input  logic          flush,
    output logic          push,
    output logic          pop,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          overrun,
    output logic          rts_n
);
    localparam logic [LW-1:0] FULL_L = LW'(DEPTH);
    localparam logic [LW-1:0] MARK_L = LW'(WMARK);

    buf_op_e       op;
    logic [LW-1:0] level_nx;
    logic          is_full;
    logic          is_empty;

    // Accept decisions; flush overrides both strobes
    always_comb begin
        is_full  = (level == FULL_L);
        is_empty = (level == '0);
        push     = rx_valid && !flush && !is_full;
        pop      = rd_en && !flush && !is_empty;
        op       = buf_op_e'({push, pop});
    end

    // Next fill level
    always_comb begin
        unique case (op)
            OP_PUSH: level_nx = level + LW'(1);
            OP_POP:  level_nx = level - LW'(1);
            default: level_nx = level;
        endcase
        if (flush) level_nx = '0;
    end

    // Level, empty flag and flow-control pin, all updated together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            empty <= 1'b1;
            rts_n <= 1'b0;
        end else begin
            level <= level_nx;
            empty <= (level_nx == '0);
            rts_n <= (level_nx >= MARK_L);
        end
    end

    // Sticky overrun: set on a dropped byte, cleared by flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush)        overrun <= 1'b0;
        else if (rx_valid && is_full) overrun <= 1'b1;
    end

endmodule

// File: rtl/rxbuf_blink.sv
// Receive activity indicator: rests high, toggles on each tick
// while a reception is in progress.
// Assumes blink_tick is a single-cycle pulse from a slow divider.
module rxbuf_blink (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_busy,
    input  logic blink_tick,
    output logic led
);
    // LED state register
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_busy) led <= 1'b1;
        else if (blink_tick)    led <= ~led;
    end

endmodule

// File: rtl/rxbuf_flow.sv
// Receive byte buffer with watermark flow control and activity LED.
// Bytes from a serial receiver are queued; the host reads the oldest.
// Assumes one clock domain; rx_busy and blink_tick are already synchronous.
module rxbuf_flow #(
    parameter int DEPTH = 480,
    parameter int WMARK = 450,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_valid,
    input  logic          rx_busy,
    input  logic          rd_en,
    input  logic          flush,
    input  logic          blink_tick,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic [LW-1:0] level,
    output logic          overrun,
    output logic          rts_n,
    output logic          rx_led
);
    logic          push;
    logic          pop;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    rxbuf_ctrl #(.DEPTH(DEPTH), .WMARK(WMARK), .LW(LW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_en(rd_en),
        .flush(flush), .push(push), .pop(pop), .level(level),
        .empty(empty), .overrun(overrun), .rts_n(rts_n)
    );

    rxbuf_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
        .clk(clk), .rst_n(rst_n), .clr(flush), .adv(push), .ptr(wr_ptr)
    );

    rxbuf_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
        .clk(clk), .rst_n(rst_n), .clr(flush), .adv(pop), .ptr(rd_ptr)
    );

    rxbuf_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
        .clk(clk), .we(push), .waddr(wr_ptr), .wdata(rx_data),
        .raddr(rd_ptr), .rdata(rd_data)
    );

    rxbuf_blink u_blink (
        .clk(clk), .rst_n(rst_n), .rx_busy(rx_busy),
        .blink_tick(blink_tick), .led(rx_led)
    );

endmodule

// File: rtl/rxbuf_flow_chk.sv
// Property checker for rxbuf_flow, attached by bind below.
module rxbuf_flow_chk #(
    parameter int DEPTH = 480,
    parameter int WMARK = 450,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rx_busy,
    input logic          rd_en,
    input logic          flush,
    input logic          blink_tick,
    input logic          empty,
    input logic [LW-1:0] level,
    input logic          overrun,
    input logic          rts_n,
    input logic          rx_led
);
    localparam logic [LW-1:0] FULL_L = LW'(DEPTH);
    localparam logic [LW-1:0] MARK_L = LW'(WMARK);

    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_L); // R4

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (level == FULL_L && rx_valid && !rd_en && !flush) |=> (level == FULL_L && overrun)); // R4

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flush) |=> overrun); // R4

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && rx_valid && rd_en && level != '0 && level != FULL_L) |=> $stable(level)); // R3

    AST_RTS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n == (level >= MARK_L)); // R5

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !rx_valid && rd_en && empty) |=> (level == '0 && empty)); // R7

    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0 && empty && !overrun)); // R8

    AST_LED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_busy |=> rx_led); // R9

    AST_LED_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy && blink_tick) |=> (rx_led != $past(rx_led))); // R10

endmodule

bind rxbuf_flow rxbuf_flow_chk #(.DEPTH(DEPTH), .WMARK(WMARK), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_busy(rx_busy),
    .rd_en(rd_en), .flush(flush), .blink_tick(blink_tick), .empty(empty),
    .level(level), .overrun(overrun), .rts_n(rts_n), .rx_led(rx_led)
);

// File: tb/rxbuf_flow_bench.sv
module rxbuf_flow_bench;
    localparam int DEPTH = 480;
    localparam int WMARK = 450;
    localparam int NVEC  = 8;

    // Vector fields: {wr, wdata[8], rd, exp_level[9], exp_empty, chk_data, exp_data[8]}
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b1, 8'hA1, 1'b0, 9'd1, 1'b0, 1'b1, 8'hA1},  // R3 push
        {1'b1, 8'hB2, 1'b0, 9'd2, 1'b0, 1'b1, 8'hA1},  // R2 head stays oldest
        {1'b1, 8'hC3, 1'b1, 9'd2, 1'b0, 1'b1, 8'hB2},  // R3 push+pop same cycle
        {1'b0, 8'h00, 1'b1, 9'd1, 1'b0, 1'b1, 8'hC3},  // R2 order
        {1'b0, 8'h00, 1'b1, 9'd0, 1'b1, 1'b0, 8'h00},  // R3 pop to empty
        {1'b0, 8'h00, 1'b1, 9'd0, 1'b1, 1'b0, 8'h00},  // R7 pop while empty
        {1'b1, 8'hD4, 1'b1, 9'd1, 1'b0, 1'b1, 8'hD4},  // R7 pop ignored, push kept
        {1'b0, 8'h00, 1'b0, 9'd1, 1'b0, 1'b1, 8'hD4}   // R2 hold
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] rx_data;
    logic       rx_valid, rx_busy, rd_en, flush, blink_tick;
    logic [7:0] rd_data;
    logic       empty, overrun, rts_n, rx_led;
    logic [8:0] level;

    int n_chk  = 0;
    int n_fail = 0;
    int wseq   = 0;
    int rseq   = 0;

    always #2 clk = ~clk;

    rxbuf_flow u_rxbuf_flow (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_busy(rx_busy), .rd_en(rd_en), .flush(flush), .blink_tick(blink_tick),
        .rd_data(rd_data), .empty(empty), .level(level), .overrun(overrun),
        .rts_n(rts_n), .rx_led(rx_led)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        rx_valid = 1'b0; rd_en = 1'b0; flush = 1'b0; blink_tick = 1'b0;
    endtask

    task automatic push_seq();
        rx_valid = 1'b1; rx_data = wseq[7:0];
        step();
        rx_valid = 1'b0;
        wseq++;
    endtask

    task automatic pop_seq(string req);
        check(req, int'(rd_data), rseq & 8'hFF);
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        rseq++;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_busy = 1'b0; rx_data = 8'h00;
        quiet();
        repeat (3) step();
        // R1 reset state
        check("R1 level", int'(level), 0);
        check("R1 empty", int'(empty), 1);
        check("R1 overrun", int'(overrun), 0);
        check("R1 rts_n", int'(rts_n), 0);
        check("R1 rx_led", int'(rx_led), 1);
        rst_n = 1'b1;
        step();

        // Port open flush
        flush = 1'b1; step(); flush = 1'b0;
        check("R8 open flush", int'(level), 0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            rx_valid = VEC[i][28];
            rx_data  = VEC[i][27:20];
            rd_en    = VEC[i][19];
            step();
            quiet();
            check("R3 vec level", int'(level), int'(VEC[i][18:10]));
            check("R3 vec empty", int'(empty), int'(VEC[i][9]));
            if (VEC[i][8]) check("R2 vec data", int'(rd_data), int'(VEC[i][7:0]));
        end
        flush = 1'b1; step(); flush = 1'b0;

        // Fill to one below the watermark
        for (int i = 0; i < WMARK - 1; i++) push_seq();
        check("R5 below mark level", int'(level), WMARK - 1);
        check("R5 below mark rts_n", int'(rts_n), 0);
        push_seq();
        check("R5 at mark rts_n", int'(rts_n), 1);
        pop_seq("R2 head at mark");
        check("R6 release level", int'(level), WMARK - 1);
        check("R6 release rts_n", int'(rts_n), 0);
        push_seq();
        check("R6 reassert rts_n", int'(rts_n), 1);
        for (int i = 0; i < DEPTH - WMARK; i++) push_seq();
        check("R4 full level", int'(level), DEPTH);
        check("R4 no overrun yet", int'(overrun), 0);
        // Byte strobed while full is dropped
        rx_valid = 1'b1; rx_data = 8'hEE; step(); rx_valid = 1'b0;
        check("R4 drop level", int'(level), DEPTH);
        check("R4 overrun set", int'(overrun), 1);
        // Drop also happens with a simultaneous read
        rx_valid = 1'b1; rx_data = 8'hEE;
        check("R2 head when full", int'(rd_data), rseq & 8'hFF);
        rd_en = 1'b1; step(); quiet(); rseq++;
        check("R4 drop with read", int'(level), DEPTH - 1);
        // Drain and check order
        for (int i = 0; i < DEPTH - 1; i++) pop_seq("R2 drain order");
        check("R3 drained level", int'(level), 0);
        check("R3 drained empty", int'(empty), 1);
        check("R5 drained rts_n", int'(rts_n), 0);
        check("R4 overrun sticky", int'(overrun), 1);

        // Flush with simultaneous write and read
        for (int i = 0; i < 3; i++) push_seq();
        flush = 1'b1; rx_valid = 1'b1; rd_en = 1'b1; rx_data = 8'h5A;
        step(); quiet();
        check("R8 flush level", int'(level), 0);
        check("R8 flush empty", int'(empty), 1);
        check("R8 flush overrun", int'(overrun), 0);
        rx_valid = 1'b1; rx_data = 8'h3C; step(); quiet();
        check("R8 no stray byte level", int'(level), 1);
        check("R8 no stray byte data", int'(rd_data), 8'h3C);

        // Activity LED
        rx_busy = 1'b0; blink_tick = 1'b1; step();
        check("R9 idle with tick", int'(rx_led), 1);
        rx_busy = 1'b1; blink_tick = 1'b0; step();
        check("R10 hold no tick", int'(rx_led), 1);
        blink_tick = 1'b1; step();
        check("R10 toggle low", int'(rx_led), 0);
        blink_tick = 1'b0; step();
        check("R10 hold low", int'(rx_led), 0);
        blink_tick = 1'b1; step();
        check("R10 toggle high", int'(rx_led), 1);
        step();
        check("R10 toggle again", int'(rx_led), 0);
        rx_busy = 1'b0; blink_tick = 1'b0; step();
        check("R9 return idle", int'(rx_led), 1);

        // Reset in mid-run
        rx_busy = 1'b1; blink_tick = 1'b1; step(); blink_tick = 1'b0;
        rst_n = 1'b0; step();
        check("R1 mid level", int'(level), 0);
        check("R1 mid empty", int'(empty), 1);
        check("R1 mid led", int'(rx_led), 1);
        rst_n = 1'b1; rx_busy = 1'b0; step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule